// File: doc/BRIEF.md
# Page-Load Write Buffer with Retriggerable Timeout

This block gathers single-byte writes into a page buffer before it commits them to a backing store. The first accepted byte opens a page. The upper address bits of that byte fix the page. The low `SLOT_W` address bits pick the slot inside the page. Each accepted byte restarts a load window. While the window is open, more bytes can join the same page. When the window runs out with no new byte, the block starts one programming cycle. At its first edge, every loaded slot is copied into the register array together.

The programming cycle has a fixed length, however many bytes were loaded. While it runs, a read of the last address written returns the last written byte with its top bit inverted. Software can poll that bit to learn when the cycle has ended. Reads of any other address return the stored contents. Writes that arrive during programming are dropped. A byte aimed at a different page while a page is loading is also dropped, and an error pulse reports it. The block is driven by qualified write events and read requests from a bus front end.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, `busy_o`, `page_err_o` and `rd_data_o` are 0 and every array byte reads 0. A write in the idle state is accepted and opens a page. `busy_o` is high from the cycle after that write until programming ends.
- R2: The page of an open load is the value of `wr_addr_i[ADDR_W-1:SLOT_W]` on its first byte. The slot of each byte is `wr_addr_i[SLOT_W-1:0]`. Bytes in the same page do not raise `page_err_o`.
- R3: Each accepted byte restarts the load window. Programming starts at the clock edge `LOAD_CYCLES` cycles after the edge that accepted the last byte. A read sampled at that same edge still returns the old array contents.
- R4: Every slot loaded in the page is written to the array at once. Slots that were not loaded keep their old values. If a slot is written more than once, the latest value wins.
- R5: Programming lasts exactly `PROG_CYCLES` cycles, whatever the number of bytes. `busy_o` falls at its end.
- R6: During programming, a read of the last accepted address returns the last accepted byte with bit `DATA_W-1` inverted and the other bits unchanged. Other addresses return the array contents. After `busy_o` falls, the true data is returned.
- R7: While a page is loading, a write whose upper address bits differ from the page is not stored and does not restart the window. `page_err_o` is high for the one cycle after it.
- R8: A write that arrives during programming leaves the array unchanged and does not raise `page_err_o`.
- R9: A read has one cycle of latency. `rd_data_o` changes only in the cycle after `rd_i` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Qualified byte-write event |
| wr_addr_i | input | ADDR_W | Write address: page in the upper bits, slot in the low SLOT_W bits |
| wr_data_i | input | DATA_W | Write byte |
| rd_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data, registered |
| busy_o | output | 1 | A page is loading or programming |
| page_err_o | output | 1 | One-cycle pulse: a byte for another page was dropped |

## Verification
The bench builds the block with an 8-bit address, 6-bit slots, an 8-cycle load window and a 12-cycle programming cycle. With only four pages, stray-page writes, slots written more than once and pages that are reloaded all occur often. The short windows make it possible to step through the exact expiry edge, a poll read, a dropped write and the fall of busy in every page. A full 64-byte page and a gap of exactly one cycle less than the window are driven on purpose.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgbuf_oneshot.sv
module pgbuf_oneshot #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i)                cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && !start_i && (cnt_q == LAST);
endmodule

// File: rtl/pgbuf_page.sv
module pgbuf_page #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 6,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clear_i,
  output logic [DATA_W-1:0] data_o [SLOTS],
  output logic [SLOTS-1:0]  mask_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              used_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        used_q <= 1'b0;
      end else begin
        if (clear_i) used_q <= 1'b0;
        if (load_i && slot_i == SLOT_W'(s)) begin
          byte_q <= data_i;
          used_q <= 1'b1;
        end
      end
    end
    assign data_o[s] = byte_q;
    assign mask_o[s] = used_q;
  end
endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 6,
  localparam int SLOTS  = 1 << SLOT_W,
  localparam int PAGE_W = ADDR_W - SLOT_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [SLOTS-1:0]  mask_i,
  input  logic [DATA_W-1:0] data_i [SLOTS],
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      // whole page lands in one edge
      for (int s = 0; s < SLOTS; s++)
        if (mask_i[s]) mem_q[{page_i, SLOT_W'(s)}] <= data_i[s];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int SLOT_W      = 6,
  parameter int LOAD_CYCLES = 15000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              page_err_o
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;

  pg_state_e         state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [DATA_W-1:0] last_data_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              err_q;

  logic              page_hit, accept_s, stray_s, commit_s;
  logic              win_done, prog_done;
  logic [DATA_W-1:0] buf_data [SLOTS];
  logic [SLOTS-1:0]  buf_mask;
  logic [DATA_W-1:0] arr_rd;

  assign page_hit = (wr_addr_i[ADDR_W-1:SLOT_W] == page_q);
  assign accept_s = wr_i && ((state_q == ST_IDLE) || (state_q == ST_LOAD && page_hit));
  assign stray_s  = wr_i && (state_q == ST_LOAD) && !page_hit;
  assign commit_s = (state_q == ST_LOAD) && win_done && !accept_s;

  pgbuf_oneshot #(.LIMIT(LOAD_CYCLES)) u_window (
    .clk_i, .rst_ni,
    .start_i (accept_s),
    .run_i   (state_q == ST_LOAD),
    .done_o  (win_done)
  );

  pgbuf_oneshot #(.LIMIT(PROG_CYCLES)) u_prog (
    .clk_i, .rst_ni,
    .start_i (commit_s),
    .run_i   (state_q == ST_PROG),
    .done_o  (prog_done)
  );

  pgbuf_page #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_page (
    .clk_i, .rst_ni,
    .load_i  (accept_s),
    .slot_i  (wr_addr_i[SLOT_W-1:0]),
    .data_i  (wr_data_i),
    .clear_i (commit_s),
    .data_o  (buf_data),
    .mask_o  (buf_mask)
  );

  pgbuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_array (
    .clk_i, .rst_ni,
    .commit_i  (commit_s),
    .page_i    (page_q),
    .mask_i    (buf_mask),
    .data_i    (buf_data),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (arr_rd)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_s)  state_d = ST_LOAD;
      ST_LOAD: if (commit_s)  state_d = ST_PROG;
      ST_PROG: if (prog_done) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      page_q      <= '0;
      last_addr_q <= '0;
      last_data_q <= '0;
      err_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= stray_s;
      if (accept_s) begin
        if (state_q == ST_IDLE) page_q <= wr_addr_i[ADDR_W-1:SLOT_W];
        last_addr_q <= wr_addr_i;
        last_data_q <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_q <= '0;
    else if (rd_i) begin
      if (state_q == ST_PROG && rd_addr_i == last_addr_q)
        rd_data_q <= {~last_data_q[DATA_W-1], last_data_q[DATA_W-2:0]};
      else
        rd_data_q <= arr_rd;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign page_err_o = err_q;
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
  parameter int PROG_CYCLES = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic busy_o,
  input logic page_err_o,
  input logic commit_s
);
  logic [31:0] since_commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       since_commit_q <= '0;
    else if (commit_s) since_commit_q <= '0;
    else               since_commit_q <= since_commit_q + 1'b1;
  end

  a_r1_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i));

  a_r7_err_from_load_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_err_o |-> ($past(wr_i) && $past(busy_o)));

  a_r4_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_s |=> (busy_o && !commit_s));

  a_r5_prog_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (since_commit_q == 32'(PROG_CYCLES)));

  a_r1_idle_write_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o);
endmodule

bind pgbuf_top pgbuf_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (.*);

// File: tb/pgbuf_top_test.sv
`timescale 1ns/1ps
module pgbuf_top_test;
  localparam int AW = 8, DW = 8, SW = 6, LC = 8, PC = 12;
  localparam int NS = 1 << SW, NA = 1 << AW, PW = AW - SW;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdata;
  logic          busy, perr;

  always #2 clk = ~clk;

  pgbuf_top #(.ADDR_W(AW), .DATA_W(DW), .SLOT_W(SW), .LOAD_CYCLES(LC), .PROG_CYCLES(PC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_i(rd), .rd_addr_i(ra), .rd_data_o(rdata), .busy_o(busy), .page_err_o(perr)
  );

  int checks = 0, errors = 0, since = 0;
  bit finished = 1'b0;
  logic [DW-1:0] mdl [NA];
  logic [DW-1:0] pend_d [NS];
  bit            pend_m [NS];
  logic [PW-1:0] page_cur;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;

  function automatic logic [DW-1:0] poll_val(logic [DW-1:0] d);
    return {~d[DW-1], d[DW-2:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    since++;
  endtask

  task automatic put(logic [AW-1:0] a, logic [DW-1:0] d);
    wr = 1'b1; wa = a; wd = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic good_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    put(a, d);
    since = 0;
    pend_d[a[SW-1:0]] = d;
    pend_m[a[SW-1:0]] = 1'b1;
    last_a = a;
    last_d = d;
    check("R2 same-page byte flags no error", perr, 0);
  endtask

  task automatic do_rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    rd = 1'b1; ra = a;
    tick();
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic commit_model();
    for (int s = 0; s < NS; s++)
      if (pend_m[s]) begin
        mdl[{page_cur, SW'(s)}] = pend_d[s];
        pend_m[s] = 1'b0;
      end
  endtask

  task automatic finish_page(logic [AW-1:0] first_a);
    logic [DW-1:0] v;
    logic [AW-1:0] da;
    logic [DW-1:0] dd;
    while (since < LC - 1) tick();
    check("R1 busy while loading", busy, 1);
    do_rd(last_a, v);
    check("R3 expiry-edge read sees old data", v, mdl[last_a]);
    commit_model();
    do_rd(last_a, v);
    check("R6 poll read inverts top bit", v, poll_val(last_d));
    da = AW'($urandom);
    dd = DW'($urandom);
    put(da, dd);
    check("R8 write during programming flags no error", perr, 0);
    do_rd(first_a, v);
    check("R4 committed byte visible during programming", v,
          (first_a == last_a) ? poll_val(last_d) : mdl[first_a]);
    while (since < LC + PC - 1) tick();
    check("R5 busy through programming", busy, 1);
    tick();
    check("R5 busy clears after PROG_CYCLES", busy, 0);
    do_rd(da, v);
    check("R8 dropped write left array unchanged", v, mdl[da]);
    do_rd(last_a, v);
    check("R6 true data after programming", v, mdl[last_a]);
  endtask

  task automatic run_page(logic [PW-1:0] pg, int n, bit seq, bit max_gap, bit stray_en);
    logic [AW-1:0] a, first_a;
    logic [DW-1:0] v;
    int tgt;
    page_cur = pg;
    check("R1 idle before page", busy, 0);
    for (int k = 0; k < n; k++) begin
      a = {pg, seq ? SW'(k) : SW'($urandom)};
      if (k == 0) first_a = a;
      else begin
        tgt = max_gap ? LC - 1 : int'($urandom_range(0, LC - 2));
        while (since < tgt) tick();
      end
      good_wr(a, DW'($urandom));
      if (k == 0) check("R1 first byte raises busy", busy, 1);
      if (stray_en && ($urandom % 4 == 0)) begin
        put({pg ^ PW'($urandom_range(1, (1 << PW) - 1)), SW'($urandom)}, DW'($urandom));
        check("R7 stray page byte pulses error", perr, 1);
      end
    end
    finish_page(first_a);
    for (int s = 0; s < NS; s++) begin
      do_rd({pg, SW'(s)}, v);
      check("R4 page readback", v, mdl[{pg, SW'(s)}]);
    end
  endtask

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'h1f2e_3d4c));
    for (int i = 0; i < NA; i++) mdl[i] = '0;
    for (int s = 0; s < NS; s++) pend_m[s] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset error flag", perr, 0);
    check("R9 reset read data", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_rd(AW'(5), v);
    check("R1 array cleared by reset", v, 0);

    run_page(2'd0, 1, 1'b0, 1'b0, 1'b0);
    run_page(2'd1, NS, 1'b1, 1'b1, 1'b0);
    // same slot twice, latest wins
    page_cur = 2'd3;
    good_wr({2'd3, 6'd9}, 8'h11);
    tick();
    good_wr({2'd3, 6'd9}, 8'hC4);
    finish_page({2'd3, 6'd9});
    do_rd({2'd3, 6'd9}, v);
    check("R4 latest value of repeated slot", v, 8'hC4);
    // rd_data holds without rd_i
    tick(); tick();
    check("R9 read data holds when idle", rdata, 8'hC4);

    for (int p = 0; p < 24; p++)
      run_page(PW'($urandom), int'($urandom_range(1, NS)), 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < NA; i++) begin
      do_rd(AW'(i), v);
      check("R4 final sweep", v, mdl[i]);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule